// File: doc/BRIEF.md
# Fetch-Address Trap and Context Push Unit

This unit lets a small processor with a banked program counter be patched or debugged without changing its program store. Software loads up to two 24-bit fetch addresses (an 8-bit bank byte above a 16-bit counter) into compare slots and enables each slot separately. The unit watches every instruction fetch. When a fetch address equals an enabled slot, it latches that address and which slot matched. It then holds an interrupt request until the core accepts it.

On acceptance, the unit writes the trap context onto a byte-wide, downward-growing stack, one byte per cycle. The context is the bank byte, then the counter (high byte first), then the 16-bit status word. In the following cycle it asks the core to set its interrupt-disable flag, to load the fixed handler vector and to take the stack pointer lowered by the frame size. The handler reads a status register that tells it which slot fired. It can then rewrite the saved bank and counter on the stack so that its return resumes past the faulty code.

Top module: `addr_trap_unit`

## Requirements
- R1: The register port is byte-wide. Compare slot k byte b is at address 4k+b, with b=0 the low byte and b=2 the bank byte. The enable register is at address 8, with bit k enabling slot k. The status register is at address 9. Writes take effect at the next clock edge, and reads return the stored value combinationally. After reset all slots and enables read 0.
- R2: A valid fetch whose 24-bit address equals an enabled slot raises `irq_req` at the next clock edge. A slot whose enable bit is 0 never raises it.
- R3: Status bit 0 reads 0 when slot 0 caused the pending trap and 1 when slot 1 caused it.
- R4: When both slots match the same fetch, slot 0 wins and status bit 0 reads 0.
- R5: A match is ignored while the interrupt-disable flag (bit 2 of `cpu_ps`) is 1. It is also ignored while a push sequence is running and while a request is already pending; the pending address and slot stay those of the first match.
- R6: `irq_req` stays high, cycle after cycle, until `irq_ack` is seen while it is high.
- R7: In the five cycles after acceptance, `stk_we` is high. `stk_addr` goes from the accepted `cpu_sp` down by one per cycle. The bytes written are: matched bank, matched counter high, matched counter low, status high, status low. The status is the value of `cpu_ps` at acceptance.
- R8: The cycle after the last stack write pulses `vec_load`, `sp_load` and `iflag_set` for one cycle. In that cycle `vec_bank`/`vec_pc` carry the fixed vector FF/FFF0 and `sp_new` equals the accepted `cpu_sp` minus 5. `irq_req` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| fetch_valid | input | 1 | Instruction fetch in this cycle |
| fetch_bank | input | 8 | Bank byte of fetch address |
| fetch_pc | input | 16 | Counter part of fetch address |
| cpu_ps | input | 16 | Current processor status; bit 2 is interrupt disable |
| cpu_sp | input | 16 | Current stack pointer |
| irq_req | output | 1 | Trap interrupt request |
| irq_ack | input | 1 | Core accepts the request |
| stk_we | output | 1 | Stack byte write strobe |
| stk_addr | output | 16 | Stack byte address |
| stk_wdata | output | 8 | Stack byte data |
| vec_load | output | 1 | Load handler vector into bank and counter |
| vec_bank | output | 8 | Handler vector bank |
| vec_pc | output | 16 | Handler vector counter |
| sp_load | output | 1 | Load `sp_new` into stack pointer |
| sp_new | output | 16 | Stack pointer after the push |
| iflag_set | output | 1 | Set the interrupt-disable flag |

## Verification
The match logic is tried with fetches that hit slot 0 only, slot 1 only, both slots at once, a disabled slot, and an address one below a slot value. Together these separate a correct equality compare from a priority swap, an ignored enable and an off-by-one compare. Status words with the disable bit set and with neighbouring bits set but bit 2 clear show that only that bit blocks a capture. A second match during a held request, and a match during the push, show that the first latched context is kept. Each accepted trap is followed byte by byte through the push, so the byte order, the address stepping and the final pointer value are all checked.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int BYTE_W   = 8;
    localparam int PG_W     = 8;
    localparam int PC_W     = 16;
    localparam int ADDR_W   = PG_W + PC_W;
    localparam int PS_W     = 16;
    localparam int SP_W     = 16;
    localparam int FRAME_W  = ADDR_W + PS_W;
    localparam int PUSH_LEN = FRAME_W / BYTE_W;
    localparam int IDX_W    = $clog2(PUSH_LEN + 1);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_PUSH = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/trap_cmp.sv
module trap_cmp #(
    parameter int AW = trap_pkg::ADDR_W
) (
    input  logic          en,
    input  logic [AW-1:0] cmp_val,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          hit
);
    always_comb begin
        hit = en && fetch_valid && (cmp_val == fetch_addr);
    end
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int NUM_CMP = 2,
    parameter int REG_AW  = 4,
    parameter int HIT_W   = 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [REG_AW-1:0]              reg_addr,
    input  logic [BYTE_W-1:0]              reg_wdata,
    output logic [BYTE_W-1:0]              reg_rdata,
    input  logic [HIT_W-1:0]               dec,
    output logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_val,
    output logic [NUM_CMP-1:0]             cmp_en
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int SLOT_STEP  = 4;
    localparam logic [REG_AW-1:0] CTRL_A = REG_AW'(SLOT_STEP * NUM_CMP);
    localparam logic [REG_AW-1:0] STAT_A = REG_AW'(SLOT_STEP * NUM_CMP + 1);

    typedef struct packed {
        logic [NUM_CMP-1:0][ADDR_W-1:0] cmp;
        logic [NUM_CMP-1:0]             en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_we) begin
            for (int k = 0; k < NUM_CMP; k++) begin
                for (int b = 0; b < ADDR_BYTES; b++) begin
                    if (reg_addr == REG_AW'(SLOT_STEP * k + b))
                        r_d.cmp[k][b*BYTE_W +: BYTE_W] = reg_wdata;
                end
            end
            if (reg_addr == CTRL_A)
                r_d.en = reg_wdata[NUM_CMP-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_CMP; k++) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (reg_addr == REG_AW'(SLOT_STEP * k + b))
                    reg_rdata = r_q.cmp[k][b*BYTE_W +: BYTE_W];
            end
        end
        if (reg_addr == CTRL_A) reg_rdata[NUM_CMP-1:0] = r_q.en;
        if (reg_addr == STAT_A) reg_rdata[HIT_W-1:0]   = dec;
    end

    assign cmp_val = r_q.cmp;
    assign cmp_en  = r_q.en;

    // R1: an enable write is visible on the next cycle
    assert_ctrl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CTRL_A) |=> (cmp_en == $past(reg_wdata[NUM_CMP-1:0])));
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int                NUM_CMP  = 2,
    parameter int                HIT_W    = 1,
    parameter int                I_BIT    = 2,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 24'hFF_FFF0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_CMP-1:0]  hit,
    input  logic [ADDR_W-1:0]   fetch_addr,
    input  logic [PS_W-1:0]     cpu_ps,
    input  logic [SP_W-1:0]     cpu_sp,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [HIT_W-1:0]    dec,
    output logic                stk_we,
    output logic [SP_W-1:0]     stk_addr,
    output logic [BYTE_W-1:0]   stk_wdata,
    output logic                vec_load,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic                sp_load,
    output logic [SP_W-1:0]     sp_new,
    output logic                iflag_set
);
    typedef struct packed {
        seq_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [SP_W-1:0]   sp;
        logic              pend;
        logic [HIT_W-1:0]  dec;
        logic [ADDR_W-1:0] saved;
        logic [PS_W-1:0]   ps;
    } seq_t;

    seq_t s_d, s_q;
    logic             any_hit;
    logic [HIT_W-1:0] win;
    logic             busy;
    logic [FRAME_W-1:0] frame;

    // lowest-numbered slot has priority
    always_comb begin
        any_hit = |hit;
        win     = '0;
        for (int k = NUM_CMP - 1; k >= 0; k--) begin
            if (hit[k]) win = HIT_W'(k);
        end
    end

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SEQ_IDLE: begin
                if (s_q.pend && irq_ack) begin
                    s_d.st  = SEQ_PUSH;
                    s_d.idx = '0;
                    s_d.sp  = cpu_sp;
                    s_d.ps  = cpu_ps;
                end else if (!s_q.pend && any_hit && !cpu_ps[I_BIT]) begin
                    s_d.pend  = 1'b1;
                    s_d.dec   = win;
                    s_d.saved = fetch_addr;
                end
            end
            SEQ_PUSH: begin
                s_d.idx = s_q.idx + 1'b1;
                if (s_q.idx == IDX_W'(PUSH_LEN - 1)) s_d.st = SEQ_FIN;
            end
            SEQ_FIN: begin
                s_d.st   = SEQ_IDLE;
                s_d.pend = 1'b0;
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy  = (s_q.st != SEQ_IDLE);
    assign frame = {s_q.saved, s_q.ps};

    always_comb begin
        stk_wdata = '0;
        for (int k = 0; k < PUSH_LEN; k++) begin
            if (s_q.idx == IDX_W'(k))
                stk_wdata = frame[FRAME_W-1-k*BYTE_W -: BYTE_W];
        end
    end

    assign irq_req   = s_q.pend;
    assign dec       = s_q.dec;
    assign stk_we    = (s_q.st == SEQ_PUSH);
    assign stk_addr  = s_q.sp - SP_W'(s_q.idx);
    assign vec_load  = (s_q.st == SEQ_FIN);
    assign vec_addr  = VEC_ADDR;
    assign sp_load   = (s_q.st == SEQ_FIN);
    assign sp_new    = s_q.sp - SP_W'(PUSH_LEN);
    assign iflag_set = (s_q.st == SEQ_FIN);

    // R2: an eligible match turns into a request
    assert_match_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !irq_req && any_hit && !cpu_ps[I_BIT]) |=> irq_req);

    // R4: slot 0 wins a simultaneous match
    assert_slot0_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !irq_req && hit[0] && !cpu_ps[I_BIT]) |=> (dec == '0));

    // R5: a request only starts from an idle, unmasked state
    assert_capture_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(!cpu_ps[I_BIT] && !busy));

    // R6: request held until taken
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !busy) |=> irq_req);

    // R7: stack address steps down one per written byte
    assert_push_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - 1'b1));

    // R8: vector load only right after the last stack write, then request drops
    assert_fin_after_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |-> $past(stk_we));
    assert_req_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !irq_req);
    assert_phase_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_we, vec_load}));
endmodule

// File: rtl/addr_trap_unit.sv
module addr_trap_unit
    import trap_pkg::*;
#(
    parameter int                NUM_CMP  = 2,
    parameter int                REG_AW   = 4,
    parameter int                I_BIT    = 2,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 24'hFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              fetch_valid,
    input  logic [PG_W-1:0]   fetch_bank,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic [PS_W-1:0]   cpu_ps,
    input  logic [SP_W-1:0]   cpu_sp,
    output logic              irq_req,
    input  logic              irq_ack,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_addr,
    output logic [BYTE_W-1:0] stk_wdata,
    output logic              vec_load,
    output logic [PG_W-1:0]   vec_bank,
    output logic [PC_W-1:0]   vec_pc,
    output logic              sp_load,
    output logic [SP_W-1:0]   sp_new,
    output logic              iflag_set
);
    localparam int HIT_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

    logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_val;
    logic [NUM_CMP-1:0]             cmp_en;
    logic [NUM_CMP-1:0]             hit;
    logic [HIT_W-1:0]               dec;
    logic [ADDR_W-1:0]              fetch_addr;
    logic [ADDR_W-1:0]              vec_addr;

    assign fetch_addr = {fetch_bank, fetch_pc};

    trap_regs #(.NUM_CMP(NUM_CMP), .REG_AW(REG_AW), .HIT_W(HIT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dec       (dec),
        .cmp_val   (cmp_val),
        .cmp_en    (cmp_en)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        trap_cmp #(.AW(ADDR_W)) u_cmp (
            .en          (cmp_en[g]),
            .cmp_val     (cmp_val[g]),
            .fetch_valid (fetch_valid),
            .fetch_addr  (fetch_addr),
            .hit         (hit[g])
        );
    end

    trap_seq #(.NUM_CMP(NUM_CMP), .HIT_W(HIT_W), .I_BIT(I_BIT), .VEC_ADDR(VEC_ADDR)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .fetch_addr (fetch_addr),
        .cpu_ps     (cpu_ps),
        .cpu_sp     (cpu_sp),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .dec        (dec),
        .stk_we     (stk_we),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .vec_load   (vec_load),
        .vec_addr   (vec_addr),
        .sp_load    (sp_load),
        .sp_new     (sp_new),
        .iflag_set  (iflag_set)
    );

    assign vec_bank = vec_addr[ADDR_W-1 -: PG_W];
    assign vec_pc   = vec_addr[PC_W-1:0];
endmodule

// File: tb/addr_trap_unit_bench.sv
`timescale 1ns/1ps
module addr_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [7:0]  fetch_bank = '0;
    logic [15:0] fetch_pc = '0;
    logic [15:0] cpu_ps = '0;
    logic [15:0] cpu_sp = 16'h01FF;
    logic        irq_req;
    logic        irq_ack = 1'b0;
    logic        stk_we;
    logic [15:0] stk_addr;
    logic [7:0]  stk_wdata;
    logic        vec_load;
    logic [7:0]  vec_bank;
    logic [15:0] vec_pc;
    logic        sp_load;
    logic [15:0] sp_new;
    logic        iflag_set;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    addr_trap_unit u_addr_trap_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
        .fetch_bank(fetch_bank), .fetch_pc(fetch_pc), .cpu_ps(cpu_ps),
        .cpu_sp(cpu_sp), .irq_req(irq_req), .irq_ack(irq_ack), .stk_we(stk_we),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .vec_load(vec_load),
        .vec_bank(vec_bank), .vec_pc(vec_pc), .sp_load(sp_load),
        .sp_new(sp_new), .iflag_set(iflag_set)
    );

    typedef struct packed {
        logic [15:0] ps;
        logic [23:0] c0;
        logic [23:0] c1;
        logic [1:0]  en;
        logic [23:0] fa;
        logic        req;
        logic        dec;
    } tv_t;

    localparam int NTV = 7;
    localparam tv_t TV [NTV] = '{
        '{16'h0000, 24'h123456, 24'h123460, 2'b11, 24'h123456, 1'b1, 1'b0},
        '{16'h0000, 24'h123456, 24'h123460, 2'b11, 24'h123460, 1'b1, 1'b1},
        '{16'h0000, 24'h123456, 24'h123460, 2'b01, 24'h123460, 1'b0, 1'b0},
        '{16'h8001, 24'h008000, 24'h008000, 2'b11, 24'h008000, 1'b1, 1'b0},
        '{16'h0004, 24'h123456, 24'h123460, 2'b11, 24'h123456, 1'b0, 1'b0},
        '{16'h0000, 24'hABFFFF, 24'h000000, 2'b01, 24'hABFFFE, 1'b0, 1'b0},
        '{16'h00F3, 24'h000000, 24'hFF0001, 2'b10, 24'hFF0001, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic load_slot(input int k, input logic [23:0] v);
        wr(4'(4*k + 0), v[7:0]);
        wr(4'(4*k + 1), v[15:8]);
        wr(4'(4*k + 2), v[23:16]);
    endtask

    // one-cycle fetch; on return we are past the capturing edge
    task automatic fetch(input logic [23:0] fa);
        @(negedge clk);
        fetch_valid = 1'b1; {fetch_bank, fetch_pc} = fa;
        @(negedge clk);
        fetch_valid = 1'b0;
    endtask

    // accept and check the whole push; optionally fetch a match mid-push
    task automatic accept(input logic [23:0] fa, input logic [15:0] ps,
                          input logic [23:0] busy_fa, input bit busy_hit);
        logic [39:0] frame;
        frame = {fa, ps};
        @(negedge clk);
        cpu_sp = 16'h01FF;
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        for (int k = 0; k < 5; k++) begin
            if (k > 0) @(negedge clk);
            if (busy_hit && k == 1) begin fetch_valid = 1'b1; {fetch_bank, fetch_pc} = busy_fa; end
            if (k == 3) fetch_valid = 1'b0;
            chk("R7", "stk_we", 32'(stk_we), 32'd1);
            chk("R7", "stk_addr", 32'(stk_addr), 32'(16'h01FF - 16'(k)));
            chk("R7", "stk_wdata", 32'(stk_wdata), 32'(frame[39-8*k -: 8]));
        end
        @(negedge clk);
        chk("R8", "vec_load", 32'(vec_load), 32'd1);
        chk("R8", "iflag_set", 32'(iflag_set), 32'd1);
        chk("R8", "sp_load", 32'(sp_load), 32'd1);
        chk("R8", "sp_new", 32'(sp_new), 32'h01FA);
        chk("R8", "vector", 32'({vec_bank, vec_pc}), 32'h00FFFFF0);
        chk("R8", "stk_we off", 32'(stk_we), 32'd0);
        @(negedge clk);
        chk("R8", "req cleared", 32'(irq_req), 32'd0);
        chk("R8", "pulse ends", 32'(vec_load), 32'd0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1", "reset irq_req", 32'(irq_req), 32'd0);
        chk("R1", "reset stk_we", 32'(stk_we), 32'd0);
        chk("R1", "reset vec_load", 32'(vec_load), 32'd0);
        rd(4'd8, d); chk("R1", "reset enables", 32'(d), 32'd0);
        rd(4'd6, d); chk("R1", "reset slot1 bank", 32'(d), 32'd0);

        // register readback
        load_slot(0, 24'hC3A55A);
        rd(4'd0, d); chk("R1", "slot0 low", 32'(d), 32'h5A);
        rd(4'd1, d); chk("R1", "slot0 mid", 32'(d), 32'hA5);
        rd(4'd2, d); chk("R1", "slot0 bank", 32'(d), 32'hC3);
        wr(4'd8, 8'h02);
        rd(4'd8, d); chk("R1", "enables", 32'(d), 32'h02);
        wr(4'd8, 8'h00);

        // vector table
        for (int i = 0; i < NTV; i++) begin
            wr(4'd8, 8'h00);
            load_slot(0, TV[i].c0);
            load_slot(1, TV[i].c1);
            wr(4'd8, {6'd0, TV[i].en});
            cpu_ps = TV[i].ps;
            fetch(TV[i].fa);
            chk(TV[i].ps[2] ? "R5" : "R2", $sformatf("vector %0d request", i),
                32'(irq_req), 32'(TV[i].req));
            if (TV[i].req) begin
                rd(4'd9, d);
                chk((TV[i].c0 == TV[i].c1) ? "R4" : "R3", $sformatf("vector %0d slot", i),
                    32'(d[0]), 32'(TV[i].dec));
                accept(TV[i].fa, TV[i].ps, 24'h0, 1'b0);
            end
        end

        // pending holds first match; request held without ack
        cpu_ps = 16'h0000;
        wr(4'd8, 8'h00);
        load_slot(0, 24'h010000);
        load_slot(1, 24'h020000);
        wr(4'd8, 8'h03);
        fetch(24'h020000);
        fetch(24'h010000);
        rd(4'd9, d); chk("R5", "slot kept while pending", 32'(d[0]), 32'd1);
        repeat (4) @(negedge clk);
        chk("R6", "request held", 32'(irq_req), 32'd1);
        // saved address must be the first match, and a match mid-push is dropped
        accept(24'h020000, 16'h0000, 24'h010000, 1'b1);
        chk("R5", "match during push dropped", 32'(irq_req), 32'd0);

        // masked by I flag, then unmasked
        cpu_ps = 16'h0004;
        fetch(24'h010000);
        chk("R5", "masked", 32'(irq_req), 32'd0);
        cpu_ps = 16'h0000;
        fetch(24'h010000);
        chk("R2", "unmasked", 32'(irq_req), 32'd1);
        rd(4'd9, d); chk("R3", "slot 0", 32'(d[0]), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule